// File: doc/BRIEF.md
# Center-Aligned Complementary PWM Channel

This block is one channel of a motor-control style timer. A counter runs up from zero to a programmed period and back down again. Each clock-enabled cycle, the count is compared with a compare value. An output-compare mode turns that comparison into a reference level. The mode is one of: hold (frozen), active-below-compare (PWM mode 1) or active-at-or-above-compare (PWM mode 2). The reference drives a complementary output pair. Both pins are forced inactive for a programmable dead time around every reference edge, and each pin has its own polarity inversion.

Period and compare values are written into preload registers. They reach the counter and comparator only at an update event, which is a turning point of the count, so a cycle in progress is never disturbed. The reference level follows the same edge-triggered rule for mode changes. It is re-evaluated only when the comparison result flips, or on the first cycle after the mode leaves frozen for a PWM mode. A direct change between the two PWM modes therefore waits for the next compare edge. Going through frozen first inverts the output at once.

Register writes use a single-cycle write port. Address 0 is the period, 1 the compare value, 2 the control word and 3 the dead time. The mode, polarity and dead-time fields act immediately. The clock enable gates the counter.

Top module: `cpwm_channel`

## Requirements
- R1: With the clock enable high, the counter steps 0,1,…,P,P-1,…,1,0,1,… and upd_o is a one-cycle pulse for each turning point. A full cycle takes 2P enabled clocks and gives two pulses.
- R2: Control field mode (bits 1:0) selects the mode: 1 is PWM mode 1, where the reference is active while count < compare. 2 is PWM mode 2, where it is active while count >= compare. 0 and 3 select frozen.
- R3: Switching the mode directly from PWM mode 1 to PWM mode 2 (or back) leaves the reference and both pins unchanged until the comparison result next changes.
- R4: In frozen mode the reference holds its level whatever the count does. The first cycle in a PWM mode after frozen re-evaluates the reference at once.
- R5: Writes to period (address 0) and compare (address 1) take effect only at the next update event. With the counter stopped, they leave the pins unchanged.
- R6: After every reference edge both pins are inactive for DT+1 clocks, where DT is the value at address 3. Then CH follows an active reference and CHN follows an inactive one.
- R7: In PWM mode 1, a compare value larger than the period keeps the reference active for the whole cycle.
- R8: Control bit 2 inverts ch_o and control bit 3 inverts chn_o, applied after dead-time insertion.
- R9: With cen_i low the count, the update pulses and the pins stay still.
- R10: After reset the mode is frozen, period, compare, dead time and polarity are zero, ch_o is 0, chn_o is 1 and upd_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_i | input | 1 | Counter clock enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 period, 1 compare, 2 control, 3 dead time |
| wr_data_i | input | CNT_W | Write data |
| ch_o | output | 1 | Main output after dead time and polarity |
| chn_o | output | 1 | Complementary output after dead time and polarity |
| upd_o | output | 1 | Update-event pulse at each counter turning point |

## Verification
The bench builds the channel with CNT_W=8 and DT_W=4. With these values a whole up/down cycle takes only ten to twenty clocks, so duty, dead-time gaps and update counts can be measured over exact multiples of the cycle. Dead times of 1 and 3 show the DT+1 gap both when it eats most of a short active pulse and when it sits inside a longer one. Stopping the counter with the clock enable freezes the comparison result. That is how the mode-switch and preload rules are checked in isolation from compare edges.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    MODE_FROZEN = 2'd0,
    MODE_PWM1   = 2'd1,
    MODE_PWM2   = 2'd2
  } oc_mode_e;

  localparam logic [1:0] ADDR_PERIOD  = 2'd0;
  localparam logic [1:0] ADDR_COMPARE = 2'd1;
  localparam logic [1:0] ADDR_CTRL    = 2'd2;
  localparam logic [1:0] ADDR_DEAD    = 2'd3;
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cen_i,
  input  logic [CNT_W-1:0] per_pre_i,
  input  logic [CNT_W-1:0] cmp_pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] cnt_q, per_act_q, cmp_act_q;
  logic             dir_up_q, upd_q, at_turn;

  assign at_turn = dir_up_q ? (cnt_q == per_act_q) : (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      per_act_q <= '0;
      cmp_act_q <= '0;
      dir_up_q  <= 1'b1;
      upd_q     <= 1'b0;
    end else begin
      upd_q <= cen_i && at_turn;
      if (cen_i) begin
        if (at_turn) begin
          per_act_q <= per_pre_i;
          cmp_act_q <= cmp_pre_i;
          if (dir_up_q) begin
            dir_up_q <= 1'b0;
            cnt_q    <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
          end else begin
            dir_up_q <= 1'b1;
            cnt_q    <= (per_pre_i == '0) ? '0 : CNT_W'(1);
          end
        end else if (dir_up_q) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign cmp_act_o = cmp_act_q;
  assign upd_o     = upd_q;

  assert_up_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_up_q |-> cnt_q <= per_act_q);
  assert_upd_turn_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> ($past(cnt_q) == '0 || $past(cnt_q) == $past(per_act_q)));
  assert_preload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_q |-> ($stable(per_act_q) && $stable(cmp_act_q)));
  assert_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cen_i |=> ($stable(cnt_q) && !upd_q));
endmodule

// File: rtl/cpwm_ref.sv
module cpwm_ref
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  oc_mode_e         mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             ref_o
);
  logic     cmp_res, cmp_prev_q, ref_q;
  oc_mode_e mode_prev_q;

  assign cmp_res = (cnt_i < cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_prev_q  <= 1'b0;
      mode_prev_q <= MODE_FROZEN;
      ref_q       <= 1'b0;
    end else begin
      cmp_prev_q  <= cmp_res;
      mode_prev_q <= mode_i;
      if (mode_i != MODE_FROZEN &&
          (mode_prev_q == MODE_FROZEN || cmp_res != cmp_prev_q)) begin
        ref_q <= (mode_i == MODE_PWM1) ? cmp_res : !cmp_res;
      end
    end
  end

  assign ref_o = ref_q;

  assert_frozen_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FROZEN) |=> $stable(ref_q));
  assert_direct_switch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_FROZEN && mode_prev_q != MODE_FROZEN && mode_i != mode_prev_q
     && cmp_res == cmp_prev_q) |=> $stable(ref_q));
  assert_pwm1_track_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PWM1 && cmp_res != cmp_prev_q) |=> (ref_q == $past(cmp_res)));
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            ch_o,
  output logic            chn_o
);
  logic            ref_d_q, busy;
  logic [DT_W-1:0] dt_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_d_q  <= 1'b0;
      dt_cnt_q <= '0;
    end else begin
      ref_d_q <= ref_i;
      if (ref_i != ref_d_q)    dt_cnt_q <= dt_i;
      else if (dt_cnt_q != '0) dt_cnt_q <= dt_cnt_q - 1'b1;
    end
  end

  // edge cycle plus DT counted cycles keep both sides off
  assign busy  = (ref_i != ref_d_q) || (dt_cnt_q != '0);
  assign ch_o  = ref_i && !busy;
  assign chn_o = !ref_i && !busy;

  assert_gap_ch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ch_o) |-> $past(!chn_o));
  assert_gap_chn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chn_o) |-> $past(!ch_o));
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cen_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             ch_o,
  output logic             chn_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] per_pre_q, cmp_pre_q, cnt, cmp_act;
  logic [DT_W-1:0]  dt_q;
  oc_mode_e         mode_q;
  logic             pol_ch_q, pol_chn_q, ref_lvl, ch_raw, chn_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_pre_q <= '0;
      cmp_pre_q <= '0;
      dt_q      <= '0;
      mode_q    <= MODE_FROZEN;
      pol_ch_q  <= 1'b0;
      pol_chn_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_PERIOD:  per_pre_q <= wr_data_i;
        ADDR_COMPARE: cmp_pre_q <= wr_data_i;
        ADDR_CTRL: begin
          mode_q    <= (wr_data_i[1:0] == 2'd3) ? MODE_FROZEN : oc_mode_e'(wr_data_i[1:0]);
          pol_ch_q  <= wr_data_i[2];
          pol_chn_q <= wr_data_i[3];
        end
        default:      dt_q <= wr_data_i[DT_W-1:0];
      endcase
    end
  end

  cpwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i, .rst_ni, .cen_i,
    .per_pre_i (per_pre_q),
    .cmp_pre_i (cmp_pre_q),
    .cnt_o     (cnt),
    .cmp_act_o (cmp_act),
    .upd_o     (upd_o)
  );

  cpwm_ref #(.CNT_W(CNT_W)) u_ref (
    .clk_i, .rst_ni,
    .mode_i (mode_q),
    .cnt_i  (cnt),
    .cmp_i  (cmp_act),
    .ref_o  (ref_lvl)
  );

  cpwm_deadtime #(.DT_W(DT_W)) u_dead (
    .clk_i, .rst_ni,
    .ref_i (ref_lvl),
    .dt_i  (dt_q),
    .ch_o  (ch_raw),
    .chn_o (chn_raw)
  );

  assign ch_o  = ch_raw ^ pol_ch_q;
  assign chn_o = chn_raw ^ pol_chn_q;

  assert_pol_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pol_ch_q && !pol_chn_q) |-> !(ch_o && chn_o));
endmodule

// File: tb/cpwm_channel_bench.sv
module cpwm_channel_bench;
  localparam int CNT_W = 8;
  localparam int DT_W  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cen = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             ch, chn, upd;
  int               checks = 0;
  int               errors = 0;

  always #10 clk = !clk;

  cpwm_channel #(.CNT_W(CNT_W), .DT_W(DT_W)) u_cpwm_channel (
    .clk_i(clk), .rst_ni(rst_n), .cen_i(cen),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ch_o(ch), .chn_o(chn), .upd_o(upd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n, output int nch, output int nchn, output int nupd);
    nch = 0; nchn = 0; nupd = 0;
    repeat (n) begin
      @(negedge clk);
      nch += int'(ch); nchn += int'(chn); nupd += int'(upd);
    end
  endtask

  task automatic t_reset;
    int a, b, u;
    measure(10, a, b, u);
    chk(a == 0, "R10 ch after reset", a, 0);
    chk(b == 10, "R10 chn after reset", b, 10);
    chk(u == 0, "R10 upd after reset", u, 0);
  endtask

  task automatic t_pwm1;
    int a, b, u;
    wr(2'd3, 1); wr(2'd0, 5); wr(2'd1, 2); wr(2'd2, 1);
    cen = 1'b1;
    idle(60);
    measure(20, a, b, u);
    chk(u == 4, "R1 update pulses per two cycles", u, 4);
    chk(a == 2, "R2 pwm1 ch high count", a, 2);
    chk(b == 10, "R6 pwm1 chn high count", b, 10);
  endtask

  task automatic t_pwm2;
    int a, b, u;
    wr(2'd2, 2);
    idle(40);
    measure(20, a, b, u);
    chk(a == 10, "R2 pwm2 ch high count", a, 10);
    chk(b == 2, "R2 pwm2 chn high count", b, 2);
  endtask

  task automatic t_switch;
    int a, b, u;
    logic c0, n0;
    wr(2'd2, 1);
    idle(40);
    cen = 1'b0;
    idle(10);
    c0 = ch; n0 = chn;
    chk(c0 != n0, "R6 settled pair complementary", int'(c0), int'(!n0));
    wr(2'd2, 2);
    measure(10, a, b, u);
    chk(a == 10 * int'(c0), "R3 direct pwm1->pwm2 keeps ch", a, 10 * int'(c0));
    chk(b == 10 * int'(n0), "R3 direct pwm1->pwm2 keeps chn", b, 10 * int'(n0));
    chk(u == 0, "R9 no update while stalled", u, 0);
    wr(2'd2, 0);
    measure(10, a, b, u);
    chk(a == 10 * int'(c0), "R4 frozen keeps ch", a, 10 * int'(c0));
    wr(2'd2, 2);
    idle(10);
    chk(ch == !c0, "R4 frozen->pwm2 inverts ch", int'(ch), int'(!c0));
    chk(chn == !n0, "R4 frozen->pwm2 inverts chn", int'(chn), int'(!n0));
    cen = 1'b1;
  endtask

  task automatic t_frozen_run;
    int a, b, u;
    wr(2'd2, 0);
    idle(10);
    measure(20, a, b, u);
    chk(a == 0 || a == 20, "R4 frozen ch constant while counting", a, 0);
    chk(a + b == 20, "R4 frozen chn complementary", a + b, 20);
    chk(u == 4, "R1 counter runs while frozen", u, 4);
  endtask

  task automatic t_preload;
    int a, b, u;
    bit hi;
    wr(2'd2, 1);
    idle(40);
    cen = 1'b0;
    idle(10);
    hi = ch;
    wr(2'd1, hi ? 0 : 9);
    idle(10);
    chk(ch == hi, "R5 compare write held until update", int'(ch), int'(hi));
    cen = 1'b1;
    idle(60);
    measure(20, a, b, u);
    chk(a == (hi ? 0 : 20), "R5 new compare active after update", a, hi ? 0 : 20);
    if (!hi) chk(a == 20, "R7 compare above period keeps ch active", a, 20);
    wr(2'd1, 9);
    idle(60);
    measure(20, a, b, u);
    chk(a == 20, "R7 compare 9 period 5 whole cycle active", a, 20);
    wr(2'd0, 3);
    idle(40);
    measure(12, a, b, u);
    chk(u == 4, "R5 new period 3 update spacing", u, 4);
  endtask

  task automatic t_deadtime;
    int a, b, u, gap;
    wr(2'd0, 10); wr(2'd1, 5); wr(2'd3, 3); wr(2'd2, 1);
    idle(80);
    measure(40, a, b, u);
    chk(a == 10, "R6 dt3 ch high count", a, 10);
    chk(b == 14, "R6 dt3 chn high count", b, 14);
    do @(negedge clk); while (!ch);
    do @(negedge clk); while (ch);
    gap = 0;
    while (!chn && gap < 50) begin gap++; @(negedge clk); end
    chk(gap == 4, "R6 gap from ch fall to chn rise", gap, 4);
    wr(2'd2, 4'b1101);
    idle(40);
    measure(40, a, b, u);
    chk(a == 30, "R8 inverted ch high count", a, 30);
    chk(b == 26, "R8 inverted chn high count", b, 26);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_pwm1();
    t_pwm2();
    t_switch();
    t_frozen_run();
    t_preload();
    t_deadtime();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule